// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order commit queue of an out-of-order core. Instructions enter at the tail in program order. Each one receives its slot index, which later travels with the result as the tag. Execution units finish in any order. They broadcast a value together with that tag, and the matching entry stores the value and becomes ready. Only the oldest entry may leave the queue, and only once it is ready. At that point a register operation becomes a register-file write and a store becomes a memory write. Until the store reaches the head, memory is never touched.

Two lookup ports let operand fetch logic read an in-flight result by tag. This covers the case where the register file is still stale. A branch that was mispredicted raises a redirect with the corrected target when it reaches the head. In the same cycle every entry is discarded, and the queue starts again from slot zero.

Top module: `spec_rob`

## Requirements
- R1: After synchronous reset the queue is empty. `iss_ready` is 1, `iss_tag` is 0, both lookup ports report not ready, and no commit output (`cmt_rf_we`, `cmt_st_we`, `redirect`) is active.
- R2: An accepted issue (`iss_valid` and `iss_ready` high at a rising edge) takes the slot shown on `iss_tag` in that cycle. Successive issues get consecutive tags that wrap from 7 to 0. The kind encoding on `iss_kind` is 0 for a register operation, 1 for a store and 2 for a branch.
- R3: When all 8 slots are occupied, `iss_ready` is 0 and an issue request takes no slot.
- R4: A broadcast (`res_valid`) writes `res_value` and `res_mispred` into the occupied slot named by `res_tag` and marks it ready. From the next cycle on, a lookup port addressed with that tag shows ready and the value.
- R5: Only the head slot retires, at most one per cycle, and only once it is ready. Younger ready slots wait behind an unready head.
- R6: A retiring register operation drives `cmt_rf_we` for one cycle, with `cmt_rf_idx` equal to bits 4:0 of its destination and `cmt_rf_data` equal to its value.
- R7: A store drives `cmt_st_we` only when it retires, with `cmt_st_addr` equal to its destination and `cmt_st_data` equal to its value.
- R8: A branch whose broadcast had `res_mispred` low retires with no register write, no store and no redirect, and then lets the next slot retire.
- R9: A ready head branch with `res_mispred` high drives `redirect` with `redirect_pc` equal to its broadcast value. In that cycle `iss_ready` is 0. After the edge every slot is empty, so the next tag is 0 and lookups of the discarded slots report not ready.
- R10: An issue and a retirement in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Kind: 0 register op, 1 store, 2 branch |
| iss_dest | input | 32 | Register number (low 5 bits) or store address |
| iss_ready | output | 1 | A slot is free and no flush is taking place |
| iss_tag | output | 3 | Slot index that an issue in this cycle receives |
| res_valid | input | 1 | Result broadcast strobe |
| res_tag | input | 3 | Slot addressed by the broadcast |
| res_value | input | 32 | Result value, store data or corrected branch target |
| res_mispred | input | 1 | Branch outcome disagreed with the prediction |
| rd0_tag | input | 3 | Lookup port 0 slot |
| rd0_ready | output | 1 | Lookup port 0 slot holds a finished result |
| rd0_value | output | 32 | Lookup port 0 value |
| rd1_tag | input | 3 | Lookup port 1 slot |
| rd1_ready | output | 1 | Lookup port 1 slot holds a finished result |
| rd1_value | output | 32 | Lookup port 1 value |
| cmt_rf_we | output | 1 | Register write at retirement |
| cmt_rf_idx | output | 5 | Register number written |
| cmt_rf_data | output | 32 | Register data |
| cmt_st_we | output | 1 | Memory write at retirement |
| cmt_st_addr | output | 32 | Store address |
| cmt_st_data | output | 32 | Store data |
| redirect | output | 1 | Mispredicted branch at the head; flush now |
| redirect_pc | output | 32 | Corrected fetch target |

## Verification
The issue tag and `iss_ready` are combinational within the request cycle. A broadcast registered at edge N becomes visible on the lookup ports and, for a ready head, on the commit outputs from just after edge N. Those commit outputs hold until edge N+1, which retires the entry. The flush state appears just after the edge that consumes `redirect`.

The bench drives every input 1 ns after a rising edge and reads combinational results before the next edge. The scoreboard monitor samples the commit outputs on each falling edge, so every retirement is seen exactly once and compared in program order with the queue of expected items.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int DATA_W = 32;
    localparam int ARF_W  = 5;

    typedef enum logic [1:0] {
        OP_REG    = 2'd0,
        OP_STORE  = 2'd1,
        OP_BRANCH = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              mispred;
        op_kind_e          kind;
        logic [DATA_W-1:0] dest;
        logic [DATA_W-1:0] value;
    } rob_entry_t;

    function automatic op_kind_e decode_kind(input logic [1:0] raw);
        case (raw)
            2'd1:    return OP_STORE;
            2'd2:    return OP_BRANCH;
            default: return OP_REG;
        endcase
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic             full
);
    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full = (occ == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NRD   = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  op_kind_e          alloc_kind,
    input  logic [DATA_W-1:0] alloc_dest,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_mispred,
    input  logic              release_en,
    input  logic [IDX_W-1:0]  head_idx,
    output rob_entry_t        head_entry,
    input  logic [IDX_W-1:0]  rd_idx   [NRD],
    output logic              rd_done  [NRD],
    output logic [DATA_W-1:0] rd_value [NRD]
);
    rob_entry_t ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_entry_t e_q;
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                e_q.busy    <= 1'b0;
                e_q.done    <= 1'b0;
                e_q.mispred <= 1'b0;
            end else if (alloc && alloc_idx == IDX_W'(i)) begin
                e_q.busy    <= 1'b1;
                e_q.done    <= 1'b0;
                e_q.mispred <= 1'b0;
                e_q.kind    <= alloc_kind;
                e_q.dest    <= alloc_dest;
                e_q.value   <= '0;
            end else begin
                if (wb_valid && wb_idx == IDX_W'(i) && e_q.busy) begin
                    e_q.done    <= 1'b1;
                    e_q.value   <= wb_value;
                    e_q.mispred <= wb_mispred;
                end
                if (release_en && head_idx == IDX_W'(i)) begin
                    e_q.busy <= 1'b0;
                    e_q.done <= 1'b0;
                end
            end
        end
        assign ent[i] = e_q;
    end

    assign head_entry = ent[head_idx];

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_done[k]  = ent[rd_idx[k]].busy && ent[rd_idx[k]].done;
        assign rd_value[k] = ent[rd_idx[k]].value;
    end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
(
    input  logic              nonempty,
    input  rob_entry_t        head,
    output logic              retire,
    output logic              flush,
    output logic              rf_we,
    output logic [ARF_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_data,
    output logic              st_we,
    output logic [DATA_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] redirect_pc
);
    always_comb begin
        retire      = nonempty && head.busy && head.done;
        flush       = retire && head.kind == OP_BRANCH && head.mispred;
        rf_we       = retire && head.kind == OP_REG;
        st_we       = retire && head.kind == OP_STORE;
        rf_idx      = head.dest[ARF_W-1:0];
        rf_data     = head.value;
        st_addr     = head.dest;
        st_data     = head.value;
        redirect_pc = head.value;
    end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [1:0]        iss_kind,
    input  logic [DATA_W-1:0] iss_dest,
    output logic              iss_ready,
    output logic [IDX_W-1:0]  iss_tag,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_mispred,
    input  logic [IDX_W-1:0]  rd0_tag,
    output logic              rd0_ready,
    output logic [DATA_W-1:0] rd0_value,
    input  logic [IDX_W-1:0]  rd1_tag,
    output logic              rd1_ready,
    output logic [DATA_W-1:0] rd1_value,
    output logic              cmt_rf_we,
    output logic [ARF_W-1:0]  cmt_rf_idx,
    output logic [DATA_W-1:0] cmt_rf_data,
    output logic              cmt_st_we,
    output logic [DATA_W-1:0] cmt_st_addr,
    output logic [DATA_W-1:0] cmt_st_data,
    output logic              redirect,
    output logic [DATA_W-1:0] redirect_pc
);
    logic [IDX_W-1:0]  head, tail;
    logic [CNT_W-1:0]  occ;
    logic              full, push, retire, flush;
    rob_entry_t        head_entry;
    logic [IDX_W-1:0]  rd_idx   [2];
    logic              rd_done  [2];
    logic [DATA_W-1:0] rd_value [2];

    assign iss_ready = !full && !flush;
    assign push      = iss_valid && iss_ready;
    assign iss_tag   = tail;
    assign redirect  = flush;

    assign rd_idx[0] = rd0_tag;
    assign rd_idx[1] = rd1_tag;
    assign rd0_ready = rd_done[0];
    assign rd0_value = rd_value[0];
    assign rd1_ready = rd_done[1];
    assign rd1_value = rd_value[1];

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .pop   (retire),
        .head  (head),
        .tail  (tail),
        .occ   (occ),
        .full  (full)
    );

    rob_slots #(.DEPTH(DEPTH), .NRD(2)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .alloc      (push),
        .alloc_idx  (tail),
        .alloc_kind (decode_kind(iss_kind)),
        .alloc_dest (iss_dest),
        .wb_valid   (res_valid),
        .wb_idx     (res_tag),
        .wb_value   (res_value),
        .wb_mispred (res_mispred),
        .release_en (retire),
        .head_idx   (head),
        .head_entry (head_entry),
        .rd_idx     (rd_idx),
        .rd_done    (rd_done),
        .rd_value   (rd_value)
    );

    rob_retire u_retire (
        .nonempty    (occ != '0),
        .head        (head_entry),
        .retire      (retire),
        .flush       (flush),
        .rf_we       (cmt_rf_we),
        .rf_idx      (cmt_rf_idx),
        .rf_data     (cmt_rf_data),
        .st_we       (cmt_st_we),
        .st_addr     (cmt_st_addr),
        .st_data     (cmt_st_data),
        .redirect_pc (redirect_pc)
    );
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [IDX_W-1:0] iss_tag,
    input logic             cmt_rf_we,
    input logic             cmt_st_we,
    input logic             redirect,
    input logic             retire,
    input logic [CNT_W-1:0] occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH)); // R3

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        occ == CNT_W'(DEPTH) |-> !iss_ready); // R3

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
        iss_valid && iss_ready |=> iss_tag == IDX_W'($past(iss_tag) + 1'b1)); // R2

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        occ == '0 |-> !retire); // R5

    AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmt_rf_we, cmt_st_we, redirect})); // R6

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        redirect |=> occ == '0 && iss_tag == '0); // R9

    AST_FLUSH_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !iss_ready); // R9

    AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (rst)
        iss_valid && iss_ready && retire |=> $stable(occ)); // R10
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .cmt_rf_we (cmt_rf_we),
    .cmt_st_we (cmt_st_we),
    .redirect  (redirect),
    .retire    (retire),
    .occ       (occ)
);

// File: tb/spec_rob_bench.sv
`timescale 1ns/1ps
module spec_rob_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_kind = 2'd0;
    logic [31:0] iss_dest = '0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        res_valid = 1'b0;
    logic [2:0]  res_tag = '0;
    logic [31:0] res_value = '0;
    logic        res_mispred = 1'b0;
    logic [2:0]  rd0_tag = '0, rd1_tag = '0;
    logic        rd0_ready, rd1_ready;
    logic [31:0] rd0_value, rd1_value;
    logic        cmt_rf_we, cmt_st_we, redirect;
    logic [4:0]  cmt_rf_idx;
    logic [31:0] cmt_rf_data, cmt_st_addr, cmt_st_data, redirect_pc;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spec_rob u_spec_rob (.*);

    typedef struct {
        int          kind;   // 0 register write, 1 store, 2 redirect
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;
    exp_t expq [$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_item(int kind, logic [31:0] addr, logic [31:0] data);
        exp_t it;
        it.kind = kind; it.addr = addr; it.data = data;
        expq.push_back(it);
    endtask

    // Monitor: commit outputs are sampled mid-cycle; each asserted cycle is one retirement.
    always @(negedge clk) begin
        if (!rst && (cmt_rf_we || cmt_st_we || redirect)) begin
            int   k;
            exp_t it;
            k = cmt_rf_we ? 0 : (cmt_st_we ? 1 : 2);
            if (expq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected retirement actual_kind=%0d expected=none", k);
            end else begin
                it = expq.pop_front();
                chk("R5 order kind", k, it.kind);
                if (k == 0) begin
                    chk("R6 rf idx", {27'd0, cmt_rf_idx}, it.addr);
                    chk("R6 rf data", cmt_rf_data, it.data);
                end else if (k == 1) begin
                    chk("R7 st addr", cmt_st_addr, it.addr);
                    chk("R7 st data", cmt_st_data, it.data);
                end else begin
                    chk("R9 redirect pc", redirect_pc, it.data);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        res_valid = 1'b0;
    endtask

    task automatic set_issue(logic [1:0] kind, logic [31:0] dest);
        iss_valid = 1'b1; iss_kind = kind; iss_dest = dest;
    endtask

    task automatic set_result(logic [2:0] tag, logic [31:0] val, logic mis);
        res_valid = 1'b1; res_tag = tag; res_value = val; res_mispred = mis;
    endtask

    task automatic issue(logic [1:0] kind, logic [31:0] dest, logic [2:0] exp_tag);
        set_issue(kind, dest);
        #1;
        chk("R2 issue ready", iss_ready, 1);
        chk("R2 issue tag", iss_tag, exp_tag);
        tick();
    endtask

    task automatic result(logic [2:0] tag, logic [31:0] val, logic mis);
        set_result(tag, val, mis);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 ready", iss_ready, 1);
        chk("R1 tag", iss_tag, 0);
        chk("R1 rd0", rd0_ready, 0);
        chk("R1 rd1", rd1_ready, 0);
        chk("R1 quiet", {cmt_rf_we, cmt_st_we, redirect}, 0);
        tick();

        // R4/R5: out-of-order completion, in-order retirement
        expect_item(0, 3, 32'hA0);
        expect_item(0, 4, 32'hA1);
        expect_item(0, 5, 32'hA2);
        issue(0, 32'h103, 0);
        issue(0, 32'h4, 1);
        issue(0, 32'h5, 2);
        result(2, 32'hA2, 0);
        result(1, 32'hA1, 0);
        rd0_tag = 2; rd1_tag = 0;
        #1;
        chk("R4 rd0 ready", rd0_ready, 1);
        chk("R4 rd0 value", rd0_value, 32'hA2);
        chk("R4 rd1 not ready", rd1_ready, 0);
        chk("R5 head blocks", {cmt_rf_we, cmt_st_we, redirect}, 0);
        result(0, 32'hA0, 0);
        repeat (4) tick();

        // R7: store held behind an unready register op
        expect_item(0, 7, 32'hB0);
        expect_item(1, 32'h1000, 32'hB1);
        issue(0, 32'h7, 3);
        issue(1, 32'h1000, 4);
        result(4, 32'hB1, 0);
        #1;
        chk("R7 store held", cmt_st_we, 0);
        result(3, 32'hB0, 0);
        repeat (4) tick();

        // R3/R2: fill all 8 slots with tag wrap, then a refused issue
        for (int i = 0; i < 8; i++) begin
            issue(0, 32'(i + 8), 3'(5 + i));
            expect_item(0, 32'(i + 8), 32'(32'hC0 + i));
        end
        set_issue(0, 32'h1F);
        #1;
        chk("R3 full stall", iss_ready, 0);
        tick();
        for (int i = 0; i < 8; i++) result(3'(5 + i), 32'(32'hC0 + i), 0);
        repeat (4) tick();

        // R10: issue and retire together keep occupancy
        for (int i = 0; i < 7; i++) issue(0, 32'(i + 16), 3'(5 + i));
        expect_item(0, 16, 32'hD0);
        result(5, 32'hD0, 0);
        set_issue(0, 32'd23);
        #1;
        chk("R10 ready at seven", iss_ready, 1);
        chk("R10 concurrent retire", cmt_rf_we, 1);
        tick();
        #1;
        chk("R10 count unchanged", iss_ready, 1);
        issue(0, 32'd24, 5);
        #1;
        chk("R10 now full", iss_ready, 0);
        for (int i = 1; i < 9; i++) begin
            expect_item(0, 32'(i + 16), 32'(32'hD0 + i));
            result(3'(5 + i), 32'(32'hD0 + i), 0);
        end
        repeat (4) tick();

        // R8: correctly predicted branch retires silently
        expect_item(0, 2, 32'hE1);
        issue(2, 32'h0, 6);
        issue(0, 32'h2, 7);
        result(7, 32'hE1, 0);
        result(6, 32'h0, 0);
        repeat (4) tick();

        // R9: mispredicted branch flush
        expect_item(0, 10, 32'hF0);
        expect_item(2, 0, 32'h400);
        issue(0, 32'd10, 0);
        issue(2, 32'h0, 1);
        issue(0, 32'd11, 2);
        issue(1, 32'h2000, 3);
        result(3, 32'hF3, 0);
        result(0, 32'hF0, 0);
        result(1, 32'h400, 1);
        set_issue(0, 32'd12);
        #1;
        chk("R9 redirect", redirect, 1);
        chk("R9 issue blocked", iss_ready, 0);
        tick();
        rd0_tag = 3;
        #1;
        chk("R9 tag restart", iss_tag, 0);
        chk("R9 store discarded", rd0_ready, 0);
        expect_item(0, 9, 32'h99);
        issue(0, 32'd9, 0);
        result(0, 32'h99, 0);
        repeat (5) tick();

        chk("R5 all retired", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule